// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the architectural registers of a 32-bit core that runs in seven processor modes. Each mode addresses sixteen general registers by a 4-bit index, and the block steers every access to the physical copy that the current mode owns. The low registers and the program counter have one copy for all modes. The upper middle registers have a second copy that only the fast-interrupt mode uses. The stack pointer and link register have a copy per exception mode. A current status register and a bank of saved-status registers, one per exception mode, complete the state.

The core drives the current 5-bit mode, two read indices, one write port, and write ports for the current and saved status. Reads are combinational from the mode and the index. All writes commit on the rising clock edge and land in the copy selected by the mode present in that cycle. A change of the mode input redirects all ports at once, with no clock edge in between.

Top module: `banked_regfile`

## Requirements
- R1: Indices 0 to 7 reach one physical copy. A value written there in any mode reads back in every mode.
- R2: Indices 8 to 12 have a copy used only in fast-interrupt mode (10001) and a second copy shared by all other modes.
- R3: Indices 13 and 14 share one copy between user (10000) and system (11111) modes. Fast-interrupt, interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes each own a separate copy of both.
- R4: Index 15 has a single copy that is the same in every mode.
- R5: The current status register has a single copy, written through its own port, and status_o shows it in every mode.
- R6: Each of the five exception modes has a private saved-status register. saved_o shows the copy of the current mode.
- R7: In user or system mode, saved_o reads zero and a saved-status write changes no saved copy.
- R8: A mode encoding other than the seven listed selects the user/system copies and reads zero as saved status.
- R9: Read outputs are combinational. A change of mode_i or an index changes the read data without a clock edge.
- R10: Writes commit on the rising edge of clk_i into the copy selected by mode_i in that cycle. With the enable low, nothing changes.
- R11: The two read ports are independent and may address any two indices, including the same one.
- R12: An active-low asynchronous reset clears every register copy, the current status and all saved status to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current processor mode |
| rd_a_idx_i | input | 4 | Read port A register index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B register index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 4 | Register write index |
| wr_data_i | input | 32 | Register write data |
| stat_we_i | input | 1 | Current status write enable |
| stat_wdata_i | input | 32 | Current status write data |
| stat_o | output | 32 | Current status value |
| saved_we_i | input | 1 | Saved status write enable |
| saved_wdata_i | input | 32 | Saved status write data |
| saved_o | output | 32 | Saved status of the current mode |

## Verification
A wrong bank mapping shows at a read port in the same cycle the mode or index changes, because the read path has no register. A write that lands in the wrong copy shows one edge later, as a stale value in the mode that should own it or as a clobbered value in a mode that should not. Stamping every register in every mode with a value unique to that mode and index, then reading all of them back in every mode, exposes any misrouted copy through the mode stamp it returns. A leak in the saved-status bank shows as a non-zero saved_o in user or system mode, or as a value from the wrong mode.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;

  localparam int NUM_EXC      = 5;
  localparam int NUM_LOGICAL  = 16;
  localparam int SHARED_N     = 8;
  localparam int FAST_FIRST   = 8;
  localparam int FAST_N       = 5;
  localparam int STACK_FIRST  = 13;
  localparam int STACK_N      = 2;
  localparam int PC_IDX       = 15;

  localparam int FAST_BASE    = SHARED_N + FAST_N;
  localparam int STACK_BASE   = FAST_BASE + FAST_N;
  localparam int PC_SLOT      = STACK_BASE + STACK_N * (NUM_EXC + 1);
  localparam int NUM_SLOTS    = PC_SLOT + 1;
  localparam int SLOT_W       = $clog2(NUM_SLOTS);
  localparam int IDX_W        = $clog2(NUM_LOGICAL);

  function automatic bank_e mode_to_bank(input logic [4:0] mode);
    bank_e b;
    case (mode)
      MODE_FIQ: b = BANK_FIQ;
      MODE_IRQ: b = BANK_IRQ;
      MODE_SVC: b = BANK_SVC;
      MODE_ABT: b = BANK_ABT;
      MODE_UND: b = BANK_UND;
      default:  b = BANK_USR;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/bank_map.sv
module bank_map
  import banked_rf_pkg::*;
(
  input  bank_e             bank_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [SLOT_W-1:0] slot_o
);

  int idx;
  int slot;

  always_comb begin
    idx = int'(idx_i);
    if (idx < SHARED_N) begin
      slot = idx;
    end else if (idx < FAST_FIRST + FAST_N) begin
      slot = (bank_i == BANK_FIQ) ? FAST_BASE + (idx - FAST_FIRST) : idx;
    end else if (idx < STACK_FIRST + STACK_N) begin
      slot = STACK_BASE + STACK_N * int'(bank_i) + (idx - STACK_FIRST);
    end else begin
      slot = PC_SLOT;
    end
    slot_o = SLOT_W'(slot);
  end

endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [SLOT_W-1:0] rd_a_slot_i,
  input  logic [SLOT_W-1:0] rd_b_slot_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o
);

  localparam int DEPTH = 2 ** SLOT_W;

  logic [DEPTH-1:0][DATA_W-1:0] mem_q;

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    if (s < NUM_SLOTS) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          mem_q[s] <= '0;
        end else if (wr_en_i && (wr_slot_i == SLOT_W'(s))) begin
          mem_q[s] <= wr_data_i;
        end
      end
    end else begin : g_pad
      assign mem_q[s] = '0;
    end
  end

  assign rd_a_o = mem_q[rd_a_slot_i];
  assign rd_b_o = mem_q[rd_b_slot_i];

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mem_q));

  assert_slot_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (int'(wr_slot_i) < NUM_SLOTS));

endmodule

// File: rtl/saved_bank.sv
module saved_bank
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  bank_e             bank_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_o
);

  logic [NUM_EXC-1:0][DATA_W-1:0] sv_q;

  for (genvar e = 0; e < NUM_EXC; e++) begin : g_exc
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sv_q[e] <= '0;
      end else if (wr_en_i && (int'(bank_i) == e + 1)) begin
        sv_q[e] <= wr_data_i;
      end
    end
  end

  always_comb begin
    rd_o = '0;
    for (int e = 0; e < NUM_EXC; e++) begin
      if (int'(bank_i) == e + 1) rd_o = sv_q[e];
    end
  end

  assert_usr_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bank_i == BANK_USR) |=> $stable(sv_q));

  assert_saved_written_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && bank_i != BANK_USR) |=> ($stable(bank_i) -> rd_o == $past(wr_data_i)));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              stat_we_i,
  input  logic [DATA_W-1:0] stat_wdata_i,
  output logic [DATA_W-1:0] stat_o,
  input  logic              saved_we_i,
  input  logic [DATA_W-1:0] saved_wdata_i,
  output logic [DATA_W-1:0] saved_o
);

  bank_e             bank;
  logic [SLOT_W-1:0] slot_a, slot_b, slot_w;
  logic [DATA_W-1:0] stat_q;

  assign bank = mode_to_bank(mode_i);

  bank_map u_map_a (.bank_i(bank), .idx_i(rd_a_idx_i), .slot_o(slot_a));
  bank_map u_map_b (.bank_i(bank), .idx_i(rd_b_idx_i), .slot_o(slot_b));
  bank_map u_map_w (.bank_i(bank), .idx_i(wr_idx_i),   .slot_o(slot_w));

  gpr_store #(.DATA_W(DATA_W)) u_gpr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_slot_i   (slot_w),
    .wr_data_i   (wr_data_i),
    .rd_a_slot_i (slot_a),
    .rd_b_slot_i (slot_b),
    .rd_a_o      (rd_a_data_o),
    .rd_b_o      (rd_b_data_o)
  );

  saved_bank #(.DATA_W(DATA_W)) u_saved (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bank_i    (bank),
    .wr_en_i   (saved_we_i),
    .wr_data_i (saved_wdata_i),
    .rd_o      (saved_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else if (stat_we_i) stat_q <= stat_wdata_i;
  end

  assign stat_o = stat_q;

  assert_rd_after_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> ((rd_a_idx_i == $past(wr_idx_i) && mode_i == $past(mode_i))
                 -> rd_a_data_o == $past(wr_data_i)));

  assert_low_shared_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < 4'd8) |=>
      ((rd_b_idx_i == $past(wr_idx_i)) -> rd_b_data_o == $past(wr_data_i)));

  assert_pc_shared_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == 4'd15) |=>
      ((rd_a_idx_i == 4'd15) -> rd_a_data_o == $past(wr_data_i)));

  assert_stat_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we_i |=> $stable(stat_o));

  assert_saved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_USR || mode_i == MODE_SYS) |-> saved_o == '0);

endmodule

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;

  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  mode_i = 5'b10000;
  logic [3:0]  rd_a_idx_i = '0, rd_b_idx_i = '0, wr_idx_i = '0;
  logic [31:0] rd_a_data_o, rd_b_data_o, stat_o, saved_o;
  logic        wr_en_i = 1'b0, stat_we_i = 1'b0, saved_we_i = 1'b0;
  logic [31:0] wr_data_i = '0, stat_wdata_i = '0, saved_wdata_i = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [4:0] modes [7] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111};

  always #(CLK_P/2) clk_i = ~clk_i;

  banked_regfile dut (.*);

  function automatic logic [31:0] stamp(int m, int i);
    return {8'(m + 1), 8'(i), 16'hC35A};
  endfunction

  // write order is modes[0..6]; m=1 fast interrupt, m=0/6 user/system
  function automatic logic [31:0] exp_gpr(int m, int i);
    if (i < 8 || i == 15) return stamp(6, i);
    if (i < 13) return (m == 1) ? stamp(1, i) : stamp(6, i);
    return (m == 0 || m == 6) ? stamp(6, i) : stamp(m, i);
  endfunction

  function automatic string req_of(int i);
    if (i < 8) return "R1";
    if (i < 13) return "R2";
    if (i < 15) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_gpr(logic [4:0] m, int i, logic [31:0] d);
    @(negedge clk_i);
    mode_i = m; wr_idx_i = 4'(i); wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 1);
    // R12: reset state
    for (int m = 0; m < 7; m++) begin
      mode_i = modes[m];
      for (int i = 0; i < 16; i++) begin
        rd_a_idx_i = 4'(i); #1;
        check("R12", rd_a_data_o, 32'h0);
      end
      check("R12", saved_o, 32'h0);
    end
    check("R12", stat_o, 32'h0);
    rst_ni = 1'b1;

    // stamp every index in every mode
    for (int m = 0; m < 7; m++)
      for (int i = 0; i < 16; i++)
        wr_gpr(modes[m], i, stamp(m, i));

    // R1-R4 via both ports, R11 port B reversed
    for (int m = 0; m < 7; m++) begin
      mode_i = modes[m];
      for (int i = 0; i < 16; i++) begin
        rd_a_idx_i = 4'(i); rd_b_idx_i = 4'(15 - i); #1;
        check(req_of(i), rd_a_data_o, exp_gpr(m, i));
        check("R11", rd_b_data_o, exp_gpr(m, 15 - i));
      end
      rd_b_idx_i = 4'd13; rd_a_idx_i = 4'd13; #1;
      check("R11", rd_b_data_o, rd_a_data_o);
    end

    // R10: enable low leaves register untouched
    @(negedge clk_i);
    mode_i = modes[2]; wr_idx_i = 4'd13; wr_data_i = 32'hFFFF_0000; wr_en_i = 1'b0;
    @(negedge clk_i);
    rd_a_idx_i = 4'd13; #1;
    check("R10", rd_a_data_o, stamp(2, 13));

    // R6/R7: saved status
    for (int m = 0; m < 7; m++) begin
      @(negedge clk_i);
      mode_i = modes[m]; saved_wdata_i = stamp(m, 20); saved_we_i = 1'b1;
      @(negedge clk_i);
      saved_we_i = 1'b0;
    end
    for (int m = 0; m < 7; m++) begin
      mode_i = modes[m]; #1;
      if (m == 0 || m == 6) check("R7", saved_o, 32'h0);
      else check("R6", saved_o, stamp(m, 20));
    end

    // R5: current status
    @(negedge clk_i);
    mode_i = modes[2]; stat_wdata_i = 32'h1234_00D3; stat_we_i = 1'b1;
    @(negedge clk_i);
    stat_we_i = 1'b0;
    for (int m = 0; m < 7; m++) begin
      mode_i = modes[m]; #1;
      check("R5", stat_o, 32'h1234_00D3);
    end

    // R9: mode change redirects without a clock edge
    @(negedge clk_i);
    mode_i = modes[0]; rd_a_idx_i = 4'd13; #1;
    check("R9", rd_a_data_o, stamp(6, 13));
    mode_i = modes[1]; #1;
    check("R9", rd_a_data_o, stamp(1, 13));
    mode_i = modes[4]; rd_a_idx_i = 4'd14; #1;
    check("R9", rd_a_data_o, stamp(4, 14));

    // R8: unknown encoding falls back to user/system copies
    wr_gpr(5'b00101, 13, 32'hDEAD_0013);
    mode_i = modes[0]; rd_a_idx_i = 4'd13; #1;
    check("R8", rd_a_data_o, 32'hDEAD_0013);
    mode_i = modes[6]; #1;
    check("R8", rd_a_data_o, 32'hDEAD_0013);
    mode_i = modes[3]; #1;
    check("R8", rd_a_data_o, stamp(3, 13));
    mode_i = 5'b00101; #1;
    check("R8", saved_o, 32'h0);
    rd_a_idx_i = 4'd9; #1;
    check("R8", rd_a_data_o, stamp(6, 9));

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule